// File: doc/BRIEF.md
# Bit-Serial Unsigned Adder

This block adds two unsigned operands of `WIDTH` bits one bit pair per clock. The least significant pair goes first. A single one-bit full adder and a carry flip-flop do the arithmetic. Two right-shifting registers hold the operands. The augend register takes each new sum bit at its most significant end, so when the add ends it holds the sum. The addend register rotates its low bit back into its top, so its value is the same after the add as before.

A one-cycle `start` pulse while the block is idle loads both operands and clears the carry. It also opens a shift window of exactly `WIDTH` clocks. The window is a clock enable driven by a down-counter; the clock itself is never gated. `busy` is high for the whole window. `done` pulses for one cycle after the last shift. At that point `sum_out` holds the low `WIDTH` bits of the sum and `carry_out` holds the carry out of the top bit.

Top module: `serial_adder`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `sum_out`, `addend_out` and `carry_out` at zero, with `busy` and `done` low.
- R2: A `start` sampled high while `busy` is low loads `a_in` into `sum_out` and `b_in` into `addend_out`, clears `carry_out` and raises `busy`, all on that edge.
- R3: After an accepted `start`, `busy` stays high for exactly `WIDTH` clock cycles and then falls.
- R4: On each edge with `busy` high, `sum_out` shifts right by one. The bit entering its MSB is `sum_out[0] ^ addend_out[0] ^ carry_out`, all taken from before the edge.
- R5: On each edge with `busy` high, `carry_out` becomes 1 when `sum_out[0]` and `addend_out[0]` are both 1. It becomes 0 when both are 0. Otherwise it keeps its value.
- R6: When `done` is high, `sum_out` equals `(a + b) mod 2^WIDTH` and `carry_out` equals bit `WIDTH` of `a + b`, where `a` and `b` are the loaded operands.
- R7: On each edge with `busy` high, `addend_out` rotates right by one, with its old bit 0 moving to its MSB. As a result, it equals the loaded addend again when `done` is high.
- R8: `done` is high for exactly one cycle. That cycle is the first cycle in which `busy` is low after a shift window.
- R9: A `start` that arrives while `busy` is high is ignored: the operation in progress keeps its operands, its result and its timing.
- R10: While `busy` and `start` are both low, `sum_out`, `addend_out` and `carry_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load operands and begin an add (ignored while busy) |
| a_in | input | WIDTH | Augend, loaded on start |
| b_in | input | WIDTH | Addend, loaded on start |
| busy | output | 1 | Shift window open |
| done | output | 1 | One-cycle pulse after the final shift |
| sum_out | output | WIDTH | Augend/sum register contents |
| addend_out | output | WIDTH | Addend register contents |
| carry_out | output | 1 | Stored carry flip-flop |

## Verification
The bench builds the block with `WIDTH = 4`. At that size all 256 operand pairs can be added one after another. Every carry chain and every possible final carry is therefore checked against sums the bench computes with ordinary arithmetic, and the window length and `done` timing are checked on every run. The small width also makes it cheap to fire a second `start` in the middle of a window and watch that the running add and its timing are unaffected.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

    typedef struct packed {
        logic sum;
        logic cout;
    } fa_out_t;

    // One-bit full adder; the carry sets on 1+1, clears on 0+0, else holds.
    function automatic fa_out_t full_add(input logic x, input logic y, input logic q);
        fa_out_t r;
        r.sum = x ^ y ^ q;
        if (x & y)
            r.cout = 1'b1;
        else if (!x && !y)
            r.cout = 1'b0;
        else
            r.cout = q;
        return r;
    endfunction

endpackage

// File: rtl/opnd_shreg.sv
module opnd_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q,
    output logic             ser_out
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift_en)
            q <= {ser_in, q[WIDTH-1:1]};
    end

    assign ser_out = q[0];
endmodule

// File: rtl/carry_cell.sv
module carry_cell
    import serial_add_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic en,
    input  logic x,
    input  logic y,
    output logic sum_bit,
    output logic carry_q
);
    fa_out_t fa;

    always_comb fa = full_add(x, y, carry_q);

    assign sum_bit = fa.sum;

    always_ff @(posedge clk) begin
        if (rst || clear)
            carry_q <= 1'b0;
        else if (en)
            carry_q <= fa.cout;
    end
endmodule

// File: rtl/shift_window.sv
module shift_window #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic active,
    output logic last
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(WIDTH);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst)
            remaining <= '0;
        else if (launch)
            remaining <= CNT_INIT;
        else if (active)
            remaining <= remaining - CNT_ONE;
    end

    assign active = (remaining != '0);
    assign last   = (remaining == CNT_ONE);
endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] sum_out,
    output logic [WIDTH-1:0] addend_out,
    output logic             carry_out
);
    logic accept;
    logic win_last;
    logic a_ser, b_ser, sum_bit;

    assign accept = start && !busy;

    shift_window #(.WIDTH(WIDTH)) u_window (
        .clk    (clk),
        .rst    (rst),
        .launch (accept),
        .active (busy),
        .last   (win_last)
    );

    opnd_shreg #(.WIDTH(WIDTH)) u_areg (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (a_in),
        .shift_en (busy),
        .ser_in   (sum_bit),
        .q        (sum_out),
        .ser_out  (a_ser)
    );

    opnd_shreg #(.WIDTH(WIDTH)) u_breg (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (b_in),
        .shift_en (busy),
        .ser_in   (b_ser),
        .q        (addend_out),
        .ser_out  (b_ser)
    );

    carry_cell u_carry (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .en      (busy),
        .x       (a_ser),
        .y       (b_ser),
        .sum_bit (sum_bit),
        .carry_q (carry_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            done <= 1'b0;
        else
            done <= win_last;
    end
endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] sum_out,
    input logic [WIDTH-1:0] addend_out,
    input logic             carry_out
);
    localparam int WC_W = $clog2(WIDTH + 1) + 1;

    logic [WC_W-1:0] win_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            win_cnt <= '0;
        else if (start && !busy)
            win_cnt <= '0;
        else if (busy)
            win_cnt <= win_cnt + WC_W'(1);
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (sum_out == '0 && addend_out == '0 && !carry_out && !busy && !done));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (sum_out == $past(a_in) && addend_out == $past(b_in)
                              && !carry_out && busy));

    assert_window_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (win_cnt == WC_W'(WIDTH)));

    assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
        busy |=> (sum_out == {$past(sum_out[0] ^ addend_out[0] ^ carry_out),
                              $past(sum_out[WIDTH-1:1])}));

    assert_carry_R5: assert property (@(posedge clk) disable iff (rst)
        busy |=> (carry_out == $past((sum_out[0] & addend_out[0]) |
                                     (carry_out & (sum_out[0] | addend_out[0])))));

    assert_rotate_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (addend_out == {$past(addend_out[0]), $past(addend_out[WIDTH-1:1])}));

    assert_done_edge_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($fell(busy) && !busy));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(sum_out) && $stable(addend_out) && $stable(carry_out)));
endmodule

bind serial_adder serial_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .a_in       (a_in),
    .b_in       (b_in),
    .busy       (busy),
    .done       (done),
    .sum_out    (sum_out),
    .addend_out (addend_out),
    .carry_out  (carry_out)
);

// File: tb/sim_serial_adder.sv
module sim_serial_adder;
    localparam int W = 4;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG_CYCLES = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         busy, done, carry_out;
    logic [W-1:0] sum_out, addend_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;

    serial_adder #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
        .busy(busy), .done(done), .sum_out(sum_out),
        .addend_out(addend_out), .carry_out(carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One full add: start on a negedge, then step to each negedge after a shift.
    task automatic run_add(input int a, input int b);
        int total;
        total = a + b;
        @(negedge clk);
        start = 1'b1; a_in = W'(a); b_in = W'(b);
        @(negedge clk);
        start = 1'b0;
        check(sum_out == W'(a), "R2 sum_out loaded", int'(sum_out), a);
        check(addend_out == W'(b) && !carry_out && busy, "R2 addend/carry/busy", int'(addend_out), b);
        for (int i = 1; i <= W; i++) begin
            @(negedge clk);
            if (i < W)
                check(busy && !done, "R3 busy inside window", int'(busy), 1);
        end
        check(!busy, "R3 busy falls after WIDTH shifts", int'(busy), 0);
        check(done, "R8 done after last shift", int'(done), 1);
        check(int'(sum_out) == (total % (1 << W)), "R4 R6 sum", int'(sum_out), total % (1 << W));
        check(int'(carry_out) == (total >> W), "R5 R6 carry", int'(carry_out), total >> W);
        check(addend_out == W'(b), "R7 addend restored", int'(addend_out), b);
        @(negedge clk);
        check(!done, "R8 done one cycle", int'(done), 0);
        check(int'(sum_out) == (total % (1 << W)) && addend_out == W'(b),
              "R10 idle hold", int'(sum_out), total % (1 << W));
    endtask

    initial begin : watchdog
        while (!finished && cycles < WATCHDOG_CYCLES) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG_CYCLES);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check(sum_out == '0 && addend_out == '0, "R1 registers cleared", int'(sum_out), 0);
        check(!busy && !done && !carry_out, "R1 flags cleared", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                run_add(a, b);

        // R9: a start inside the window must not disturb the add in flight.
        @(negedge clk);
        start = 1'b1; a_in = W'(3); b_in = W'(5);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        start = 1'b1; a_in = W'(15); b_in = W'(15);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(!busy && done, "R9 timing unaffected", int'(busy), 0);
        check(int'(sum_out) == 8 && !carry_out, "R9 result unaffected", int'(sum_out), 8);
        check(addend_out == W'(5), "R9 addend unaffected", int'(addend_out), 5);

        // R10: outputs hold over a long idle stretch.
        repeat (5) @(negedge clk);
        check(int'(sum_out) == 8 && addend_out == W'(5) && !busy, "R10 long idle", int'(sum_out), 8);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule